// File: doc/BRIEF.md
# Card-Interface Transfer FIFO with Data Request

This block sits between a bus master (a processor or a DMA controller) and a serial card-protocol engine. It buffers data in a four-word FIFO of 64-bit words. It counts the words of a programmed transfer and asks the bus master for service only while the transfer is open and the FIFO can take or give a word.

Software, or the protocol sequencer, programs a byte count and a direction and then pulses `start`. The bus side moves data as 32-bit halves, low half first, and every second access completes one 64-bit word. The engine side pushes or pops whole 64-bit words.

The same request condition drives two outputs. `dma_req` is a live level for the DMA controller. `drq_status` is a sticky status bit that any bus-side FIFO strobe clears. When the last word crosses the bus side, a one-cycle `done` pulse closes the transfer.

Top module: `cardbuf_top`

## Requirements
- R1: After synchronous reset (`rst`=1 at a clock edge), `xfer_active`, `words_left`, `dma_req`, `drq_status`, `done`, `cfg_err` and `eng_valid` are all 0, and the FIFO is empty.
- R2: A `start` pulse while idle with a byte count that is nonzero and a multiple of 8 (`cfg_size[2:0]`=0) has four effects. It sets `xfer_active`, loads `words_left` with `cfg_size/8`, empties the FIFO, and latches the direction (`cfg_dir`=1 write: the bus fills and the engine drains; `cfg_dir`=0 read: the engine fills and the bus drains). A `start` while `xfer_active`=1 is ignored.
- R3: A `start` while idle whose byte count is zero or has `cfg_size[2:0]`≠0 sets `cfg_err` and leaves the block idle. The next accepted `start` clears `cfg_err`.
- R4: Write mode: a bus write is accepted only while active and the FIFO (4 words deep) is not full. The first accepted write supplies bits [31:0] of a word and the second supplies bits [63:32]. The engine sees the FIFO head on `eng_rdata` with `eng_valid`=1 and pops it with `eng_pop`, in first-in first-out order, even after `done`.
- R5: Read mode: an engine push is accepted while `eng_ready`=1 (active and FIFO not full). `bus_rdata` shows bits [31:0] of the head word, then bits [63:32] after one accepted `bus_rd_en`. The second accepted read pops the word.
- R6: `dma_req` = `xfer_active` AND (write mode ? FIFO not full : FIFO not empty).
- R7: `drq_status` becomes 1 one cycle after the `dma_req` condition holds and then stays set. Any `bus_wr_en` or `bus_rd_en` strobe clears it, accepted or not. An accepted `start` and the end of the transfer also clear it.
- R8: `words_left` decreases by exactly one for each 64-bit word that completes on the bus side and is otherwise unchanged.
- R9: When the last word crosses the bus side, `done` is 1 for exactly one cycle and `xfer_active` falls at the same edge. After that, the requests stay low and bus accesses and engine pushes are ignored until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir | input | 1 | Direction for the next start: 1 write, 0 read |
| cfg_size | input | 16 | Transfer size in bytes |
| start | input | 1 | Start pulse |
| bus_wr_en | input | 1 | Bus-side FIFO write strobe (32-bit half) |
| bus_wdata | input | 32 | Bus-side write data |
| bus_rd_en | input | 1 | Bus-side FIFO read strobe (32-bit half) |
| bus_rdata | output | 32 | Current half of the FIFO head word |
| eng_push | input | 1 | Engine push strobe (read mode) |
| eng_wdata | input | 64 | Engine push data |
| eng_ready | output | 1 | Engine push would be accepted |
| eng_pop | input | 1 | Engine pop strobe (write mode) |
| eng_rdata | output | 64 | FIFO head word for the engine |
| eng_valid | output | 1 | Head word available to the engine |
| xfer_active | output | 1 | Transfer open |
| words_left | output | 13 | 64-bit words still to cross the bus side |
| dma_req | output | 1 | Request line to the DMA controller |
| drq_status | output | 1 | Sticky data-request status bit |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | Last start had a zero or unaligned size |

## Verification
The FIFO pointers and count decide `eng_valid`, `eng_ready` and `dma_req` in the same cycle. A wrong pointer or count therefore shows at once as a request at a full or empty FIFO, or later as a word that comes out in the wrong order.

A half-select that drifts shows up on the next 64-bit word as swapped halves on `eng_rdata` or `bus_rdata`. A miscounting word counter shows as a `words_left` mismatch after the first word and as a `done` pulse on the wrong edge. The directed scenarios therefore compare every word, the counter and the request levels after each access, so an error surfaces within one word of its cause.

// File: rtl/cardbuf_pkg.sv
package cardbuf_pkg;

  // Transfer direction, latched at start.
  typedef enum logic {
    XDIR_READ  = 1'b0,  // engine fills, bus drains
    XDIR_WRITE = 1'b1   // bus fills, engine drains
  } xdir_e;

endpackage

// File: rtl/cardbuf_fifo.sv
module cardbuf_fifo #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              full,
  output logic              empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  // Storage without reset so that a RAM can be inferred.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R4: the surrounding logic never pushes into a full FIFO
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    !(push && full && !flush));

  // R5: the surrounding logic never pops an empty FIFO
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty && !flush));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

endmodule

// File: rtl/cardbuf_bus_port.sv
module cardbuf_bus_port
  import cardbuf_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              active,
  input  xdir_e             dir_q,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_head,
  input  logic              bus_wr_en,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd_en,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              fifo_pop,
  output logic              word_xfer,
  output logic              bus_touch
);

  localparam int PARTS  = WORD_W / BUS_W;
  localparam int PW     = (PARTS > 1) ? $clog2(PARTS) : 1;
  localparam int HOLD_W = WORD_W - BUS_W;
  localparam logic [PW-1:0] PLAST = PW'(PARTS - 1);

  logic [PW-1:0]     part;
  logic [HOLD_W-1:0] hold;
  logic              wr_ok, rd_ok, last;

  assign last  = (part == PLAST);
  assign wr_ok = bus_wr_en && active && (dir_q == XDIR_WRITE) && !fifo_full;
  assign rd_ok = bus_rd_en && active && (dir_q == XDIR_READ) && !fifo_empty;

  assign fifo_push  = wr_ok && last;
  assign fifo_pop   = rd_ok && last;
  assign word_xfer  = fifo_push || fifo_pop;
  assign bus_touch  = bus_wr_en || bus_rd_en;
  assign fifo_wdata = {bus_wdata, hold};
  assign bus_rdata  = fifo_head[int'(part)*BUS_W +: BUS_W];

  // Part index: low half first, shared by both directions.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      part <= '0;
    end else if (wr_ok || rd_ok) begin
      part <= last ? '0 : part + PW'(1);
    end
  end

  // Lower parts of an outgoing word wait here for the top part.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (wr_ok && !last) begin
      hold[int'(part)*BUS_W +: BUS_W] <= bus_wdata;
    end
  end

  // R9: strobes while no transfer is open leave the half pointer alone
  p_idle_touch_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_touch && !active && !flush) |=> $stable(part));

  // R4/R5: a word completes only on the top half
  p_word_on_last_r4: assert property (@(posedge clk) disable iff (rst)
    word_xfer |-> (part == PLAST));

endmodule

// File: rtl/cardbuf_ctrl.sv
module cardbuf_ctrl
  import cardbuf_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int WB_SH  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    cfg_dir,
  input  logic [SIZE_W-1:0]       cfg_size,
  input  logic                    word_xfer,
  input  logic                    bus_touch,
  input  logic                    fifo_full,
  input  logic                    fifo_empty,
  output logic                    flush,
  output logic                    active,
  output xdir_e                   dir_q,
  output logic [SIZE_W-WB_SH-1:0] words_left,
  output logic                    dma_req,
  output logic                    drq_status,
  output logic                    done,
  output logic                    cfg_err
);

  localparam int WL_W = SIZE_W - WB_SH;

  logic size_ok, start_go, start_bad, last_word, req_cond;

  assign size_ok   = (cfg_size[WB_SH-1:0] == '0) && (cfg_size != '0);
  assign start_go  = start && !active && size_ok;
  assign start_bad = start && !active && !size_ok;
  assign last_word = active && word_xfer && (words_left == WL_W'(1));
  assign flush     = start_go;

  assign req_cond = active &&
                    ((dir_q == XDIR_WRITE) ? !fifo_full : !fifo_empty);
  assign dma_req  = req_cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      dir_q      <= XDIR_READ;
      words_left <= '0;
      done       <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_go) begin
        active     <= 1'b1;
        dir_q      <= xdir_e'(cfg_dir);
        words_left <= cfg_size[SIZE_W-1:WB_SH];
        cfg_err    <= 1'b0;
      end else if (start_bad) begin
        cfg_err <= 1'b1;
      end else if (active && word_xfer) begin
        words_left <= words_left - WL_W'(1);
        if (last_word) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // Sticky status: set by the request condition, cleared by any bus strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      drq_status <= 1'b0;
    end else if (start_go || bus_touch || last_word) begin
      drq_status <= 1'b0;
    end else if (req_cond) begin
      drq_status <= 1'b1;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && words_left == '0 && !dma_req));

  p_req_active_r6: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> active);

  p_words_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !word_xfer && !start) |=> $stable(words_left));

  p_err_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> !active);

  p_drq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    bus_touch |=> !drq_status);

endmodule

// File: rtl/cardbuf_top.sv
module cardbuf_top
  import cardbuf_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 4,
  parameter int SIZE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_dir,
  input  logic [SIZE_W-1:0]         cfg_size,
  input  logic                      start,
  input  logic                      bus_wr_en,
  input  logic [BUS_W-1:0]          bus_wdata,
  input  logic                      bus_rd_en,
  output logic [BUS_W-1:0]          bus_rdata,
  input  logic                      eng_push,
  input  logic [WORD_W-1:0]         eng_wdata,
  output logic                      eng_ready,
  input  logic                      eng_pop,
  output logic [WORD_W-1:0]         eng_rdata,
  output logic                      eng_valid,
  output logic                      xfer_active,
  output logic [SIZE_W-$clog2(WORD_W/8)-1:0] words_left,
  output logic                      dma_req,
  output logic                      drq_status,
  output logic                      done,
  output logic                      cfg_err
);

  localparam int WB_SH = $clog2(WORD_W / 8);

  xdir_e             dir_q;
  logic              flush, active;
  logic              f_push, f_pop, f_full, f_empty;
  logic [WORD_W-1:0] f_wdata, f_head;
  logic              b_push, b_pop, word_xfer, bus_touch;
  logic [WORD_W-1:0] b_wdata;
  logic              e_push_ok, e_pop_ok;

  assign eng_ready   = active && (dir_q == XDIR_READ) && !f_full;
  assign eng_valid   = (dir_q == XDIR_WRITE) && !f_empty;
  assign eng_rdata   = f_head;
  assign e_push_ok   = eng_push && eng_ready;
  assign e_pop_ok    = eng_pop && eng_valid;
  assign xfer_active = active;

  // Each direction gives the push side to one party and the pop side to the other.
  always_comb begin
    if (dir_q == XDIR_WRITE) begin
      f_push  = b_push;
      f_wdata = b_wdata;
      f_pop   = e_pop_ok;
    end else begin
      f_push  = e_push_ok;
      f_wdata = eng_wdata;
      f_pop   = b_pop;
    end
  end

  cardbuf_ctrl #(
    .SIZE_W(SIZE_W),
    .WB_SH (WB_SH)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_dir   (cfg_dir),
    .cfg_size  (cfg_size),
    .word_xfer (word_xfer),
    .bus_touch (bus_touch),
    .fifo_full (f_full),
    .fifo_empty(f_empty),
    .flush     (flush),
    .active    (active),
    .dir_q     (dir_q),
    .words_left(words_left),
    .dma_req   (dma_req),
    .drq_status(drq_status),
    .done      (done),
    .cfg_err   (cfg_err)
  );

  cardbuf_bus_port #(
    .BUS_W (BUS_W),
    .WORD_W(WORD_W)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .active    (active),
    .dir_q     (dir_q),
    .fifo_full (f_full),
    .fifo_empty(f_empty),
    .fifo_head (f_head),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rd_en (bus_rd_en),
    .bus_rdata (bus_rdata),
    .fifo_push (b_push),
    .fifo_wdata(b_wdata),
    .fifo_pop  (b_pop),
    .word_xfer (word_xfer),
    .bus_touch (bus_touch)
  );

  cardbuf_fifo #(
    .WORD_W(WORD_W),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .flush(flush),
    .push (f_push),
    .wdata(f_wdata),
    .pop  (f_pop),
    .head (f_head),
    .full (f_full),
    .empty(f_empty)
  );

  // R6: in read mode a request never points at an empty FIFO
  p_req_read_data_r6: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dir_q == XDIR_READ) |-> !f_empty);

  // R6: in write mode a request never points at a full FIFO
  p_req_write_room_r6: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dir_q == XDIR_WRITE) |-> !f_full);

  // R9: an idle block accepts no engine data
  p_idle_no_push_r9: assert property (@(posedge clk) disable iff (rst)
    !active |-> !eng_ready);

endmodule

// File: tb/cardbuf_top_tb.sv
module cardbuf_top_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_dir;
  logic [15:0] cfg_size;
  logic        start;
  logic        bus_wr_en, bus_rd_en;
  logic [31:0] bus_wdata, bus_rdata;
  logic        eng_push, eng_pop, eng_ready, eng_valid;
  logic [63:0] eng_wdata, eng_rdata;
  logic        xfer_active, dma_req, drq_status, done, cfg_err;
  logic [12:0] words_left;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  cardbuf_top u_dut (
    .clk(clk), .rst(rst), .cfg_dir(cfg_dir), .cfg_size(cfg_size), .start(start),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
    .bus_rdata(bus_rdata), .eng_push(eng_push), .eng_wdata(eng_wdata),
    .eng_ready(eng_ready), .eng_pop(eng_pop), .eng_rdata(eng_rdata),
    .eng_valid(eng_valid), .xfer_active(xfer_active), .words_left(words_left),
    .dma_req(dma_req), .drq_status(drq_status), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic dir, input logic [15:0] size);
    @(negedge clk);
    cfg_dir = dir; cfg_size = size; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic bus_write64(input logic [63:0] v);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_wdata = v[31:0];
    @(negedge clk);
    bus_wdata = v[63:32];
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read64(output logic [63:0] v);
    @(negedge clk);
    v[31:0] = bus_rdata; bus_rd_en = 1'b1;
    @(negedge clk);
    v[63:32] = bus_rdata;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic eng_push_w(input logic [63:0] v);
    @(negedge clk);
    eng_push = 1'b1; eng_wdata = v;
    @(negedge clk);
    eng_push = 1'b0;
  endtask

  task automatic eng_pop_w(output logic [63:0] v);
    @(negedge clk);
    v = eng_rdata; eng_pop = 1'b1;
    @(negedge clk);
    eng_pop = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 active", xfer_active, 0);
    chk("R1 words_left", words_left, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 drq", drq_status, 0);
    chk("R1 done", done, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 eng_valid", eng_valid, 0);
  endtask

  task automatic t_write();
    logic [63:0] w [6];
    logic [63:0] got;
    for (int i = 0; i < 6; i++) w[i] = {32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i)};
    do_start(1'b1, 16'd48);
    chk("R2 active after start", xfer_active, 1);
    chk("R2 words loaded", words_left, 6);
    chk("R6 req write empty", dma_req, 1);
    @(negedge clk);
    chk("R7 drq set", drq_status, 1);
    bus_write64(w[0]);
    chk("R7 drq cleared by access", drq_status, 0);
    chk("R8 words after one", words_left, 5);
    @(negedge clk);
    chk("R7 drq set again", drq_status, 1);
    for (int i = 1; i < 4; i++) bus_write64(w[i]);
    chk("R6 req low when full", dma_req, 0);
    chk("R4 engine sees data", eng_valid, 1);
    chk("R8 words after four", words_left, 2);
    bus_write64(64'hDEAD_BEEF_DEAD_BEEF);
    chk("R4 write to full ignored", words_left, 2);
    for (int i = 0; i < 2; i++) begin
      eng_pop_w(got);
      chk("R4 engine order", got, w[i]);
    end
    @(negedge clk);
    chk("R6 req back with room", dma_req, 1);
    bus_write64(w[4]);
    bus_write64(w[5]);
    chk("R9 done pulse", done, 1);
    chk("R9 inactive", xfer_active, 0);
    chk("R9 words zero", words_left, 0);
    chk("R9 req low", dma_req, 0);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R9 drq low", drq_status, 0);
    bus_write64(64'h1111_2222_3333_4444);
    for (int i = 2; i < 6; i++) begin
      eng_pop_w(got);
      chk("R4 drain after done", got, w[i]);
    end
    @(negedge clk);
    chk("R9 write after done ignored", eng_valid, 0);
  endtask

  task automatic t_read_small();
    logic [63:0] got;
    do_start(1'b0, 16'd16);
    chk("R6 read req empty", dma_req, 0);
    chk("R5 engine ready", eng_ready, 1);
    eng_push_w(64'h0123_4567_89AB_CDEF);
    chk("R6 read req data", dma_req, 1);
    bus_read64(got);
    chk("R5 halves low then high", got, 64'h0123_4567_89AB_CDEF);
    chk("R8 words after read", words_left, 1);
    chk("R6 req low empty again", dma_req, 0);
    do_start(1'b0, 16'd64);
    chk("R2 start while active ignored", words_left, 1);
    eng_push_w(64'hFEDC_BA98_7654_3210);
    bus_read64(got);
    chk("R5 second word", got, 64'hFEDC_BA98_7654_3210);
    chk("R9 done on read", done, 1);
    chk("R9 inactive read", xfer_active, 0);
    chk("R9 no push after done", eng_ready, 0);
  endtask

  task automatic t_read_full();
    logic [63:0] got;
    do_start(1'b0, 16'd64);
    chk("R2 words eight", words_left, 8);
    for (int i = 0; i < 4; i++) eng_push_w(64'hC0DE_0000_0000_0000 + 64'(i));
    chk("R4 depth four full", eng_ready, 0);
    eng_push_w(64'hBAD0_BAD0_BAD0_BAD0);
    for (int i = 0; i < 4; i++) begin
      bus_read64(got);
      chk("R5 read order", got, 64'hC0DE_0000_0000_0000 + 64'(i));
    end
    chk("R8 words four left", words_left, 4);
    chk("R4 push to full ignored", dma_req, 0);
    chk("R5 ready after drain", eng_ready, 1);
  endtask

  task automatic t_bad_size();
    do_reset();
    do_start(1'b1, 16'd12);
    chk("R3 unaligned err", cfg_err, 1);
    chk("R3 unaligned idle", xfer_active, 0);
    do_start(1'b1, 16'd0);
    chk("R3 zero err", cfg_err, 1);
    chk("R3 zero idle", dma_req, 0);
    do_start(1'b1, 16'd8);
    chk("R3 err cleared", cfg_err, 0);
    chk("R2 one word", words_left, 1);
    bus_write64(64'h7777_8888_9999_AAAA);
    chk("R9 single word done", done, 1);
  endtask

  task automatic t_mid_reset();
    do_start(1'b1, 16'd32);
    bus_write64(64'h1);
    do_reset();
    chk("R1 reset clears active", xfer_active, 0);
    chk("R1 reset clears words", words_left, 0);
    chk("R1 reset empties fifo", eng_valid, 0);
  endtask

  initial begin
    rst = 1'b1; cfg_dir = 1'b0; cfg_size = '0; start = 1'b0;
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_wdata = '0;
    eng_push = 1'b0; eng_pop = 1'b0; eng_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_read_small();
    t_read_full();
    t_bad_size();
    t_mid_reset();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule